// File: doc/BRIEF.md
# Programmable Priority Interrupt Arbiter

This block decides which interrupt request should be serviced next. Every device interrupt line owns one byte-wide priority register. Software reaches these registers through a small byte-wide register bus. Device interrupt k sits at byte address `BASE_OFS + k`. Only the upper `PRIO_BITS` bits of each byte are kept in storage. The lower bits are dropped on write and return zero on read. A numerically smaller stored value means a more urgent request.

In every cycle the block takes three sets of inputs: a pending vector, an enable vector, and two fixed-rank requests. The fixed-rank requests are a non-maskable interrupt and a hard-fault request. From these it picks a single winner and registers it. It then presents the winner as an exception number with a valid flag. The exception number is 2 for the non-maskable request, 3 for the hard fault, and 16+k for device interrupt k.

The block does not look at the priority of the code that is currently running, and it does not fetch vectors. Those jobs belong to the consumer of the winner output.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After a synchronous reset, every priority register reads 0 and `win_valid` is low with `win_exc` equal to 0.
- R2: A write keeps only the upper `PRIO_BITS` bits of `bus_wdata`. The remaining low bits read back as zero. With `PRIO_BITS`=3, writing 0xFF reads back 0xE0 and writing 0x5F reads back 0x40.
- R3: Priority register k is written and read at `bus_addr` = `BASE_OFS`+k. A write to an address outside `BASE_OFS` .. `BASE_OFS+NUM_IRQ-1` changes no register. A read from such an address returns 0.
- R4: Among device interrupts that are both pending and enabled, the one with the numerically smallest priority value wins, and `win_exc` reports 16+k.
- R5: When eligible device interrupts share the smallest priority value, the one with the lowest index k wins.
- R6: A device interrupt that is pending but not enabled, or enabled but not pending, never wins.
- R7: A non-maskable request wins over everything else. It reports exception number 2, whatever the enables and priorities are.
- R8: A hard-fault request wins over all device interrupts and reports exception number 3. It loses only to a non-maskable request.
- R9: When nothing is eligible, `win_valid` is low and `win_exc` is 0.
- R10: The outputs are registered. A change on pending, enable or the fixed-rank request inputs appears after the next rising edge. A priority write takes effect in the arbitration one edge after the register itself updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the priority registers |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_pend | input | NUM_IRQ | Pending flag per device interrupt |
| irq_en | input | NUM_IRQ | Enable flag per device interrupt |
| nmi_req | input | 1 | Non-maskable request |
| hardfault_req | input | 1 | Hard-fault request |
| win_valid | output | 1 | A winner is being presented |
| win_exc | output | EXC_W | Exception number of the winner |

## Verification
Assertions in the top module are evaluated on every cycle and cover four rules:
- the non-maskable request always comes first;
- a hard fault ranks second;
- the output is idle whenever nothing was eligible one cycle earlier;
- a device winner was pending and enabled in that cycle.

Some behaviour can only be shown by the bench's scenarios: the ordering by stored priority value, lowest-index tie breaking, the truncation of low priority bits, decoding of addresses out of range, and the extra cycle of delay after a priority write. A behavioural model in the bench checks each of these against the outputs on every clock.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int PRIO_W       = 8;
    localparam int NMI_EXC      = 2;
    localparam int HF_EXC       = 3;
    localparam int DEV_EXC_BASE = 16;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_FAULT,
        SRC_DEV
    } win_src_e;

    typedef struct packed {
        logic              hit;
        logic [PRIO_W-1:0] prio;
        logic [7:0]        idx;
    } cand_t;

    // Keep the top 'bits' bits of a priority byte, clear the rest.
    function automatic logic [PRIO_W-1:0] keep_upper(input logic [PRIO_W-1:0] v,
                                                     input int bits);
        logic [PRIO_W-1:0] r;
        for (int b = 0; b < PRIO_W; b++) begin
            r[b] = (b >= PRIO_W - bits) ? v[b] : 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_BITS = 3,
    parameter int ADDR_W    = 12,
    parameter int BASE_OFS  = 'h400
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [PRIO_W-1:0]          bus_wdata,
    output logic [PRIO_W-1:0]          bus_rdata,
    output logic [NUM_IRQ*PRIO_W-1:0]  prio_flat
);

    localparam int LOW_BITS = PRIO_W - PRIO_BITS;

    logic [ADDR_W-1:0] offset;
    logic              in_range;

    assign offset   = bus_addr - ADDR_W'(BASE_OFS);
    assign in_range = (bus_addr >= ADDR_W'(BASE_OFS)) && (offset < ADDR_W'(NUM_IRQ));

    genvar k;
    generate
        for (k = 0; k < NUM_IRQ; k++) begin : g_slot
            logic [PRIO_BITS-1:0] level_q;
            logic                 sel;

            assign sel = in_range && (offset == ADDR_W'(k));

            always_ff @(posedge clk) begin
                if (rst) begin
                    level_q <= '0;
                end else if (bus_wr && sel) begin
                    level_q <= bus_wdata[PRIO_W-1 -: PRIO_BITS];
                end
            end

            assign prio_flat[k*PRIO_W +: PRIO_W] = {level_q, {LOW_BITS{1'b0}}};
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (in_range && (offset == ADDR_W'(i))) begin
                bus_rdata = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    input  logic [NUM_IRQ-1:0]        irq_pend,
    input  logic [NUM_IRQ-1:0]        irq_en,
    output cand_t                     best
);

    logic [NUM_IRQ-1:0] eligible;

    genvar k;
    generate
        for (k = 0; k < NUM_IRQ; k++) begin : g_elig
            assign eligible[k] = irq_pend[k] & irq_en[k];
        end
    endgenerate

    // Scan from the top index down; '<=' lets a lower index take ties.
    always_comb begin
        best = '{hit: 1'b0, prio: '1, idx: '0};
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (eligible[i] && (!best.hit || prio_flat[i*PRIO_W +: PRIO_W] <= best.prio)) begin
                best.hit  = 1'b1;
                best.prio = prio_flat[i*PRIO_W +: PRIO_W];
                best.idx  = 8'(i);
            end
        end
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_BITS = 3,
    parameter int ADDR_W    = 12,
    parameter int BASE_OFS  = 'h400,
    parameter int EXC_W     = $clog2(DEV_EXC_BASE + NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic               nmi_req,
    input  logic               hardfault_req,
    output logic               win_valid,
    output logic [EXC_W-1:0]   win_exc
);

    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
    cand_t                     dev_best;
    win_src_e                  src;
    logic [EXC_W-1:0]          exc_d;

    irq_prio_regs #(
        .NUM_IRQ  (NUM_IRQ),
        .PRIO_BITS(PRIO_BITS),
        .ADDR_W   (ADDR_W),
        .BASE_OFS (BASE_OFS)
    ) regs_i (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .prio_flat(prio_flat)
    );

    irq_prio_select #(
        .NUM_IRQ(NUM_IRQ)
    ) sel_i (
        .prio_flat(prio_flat),
        .irq_pend (irq_pend),
        .irq_en   (irq_en),
        .best     (dev_best)
    );

    always_comb begin
        if (nmi_req)            src = SRC_NMI;
        else if (hardfault_req) src = SRC_FAULT;
        else if (dev_best.hit)  src = SRC_DEV;
        else                    src = SRC_NONE;
    end

    always_comb begin
        unique case (src)
            SRC_NMI:   exc_d = EXC_W'(NMI_EXC);
            SRC_FAULT: exc_d = EXC_W'(HF_EXC);
            SRC_DEV:   exc_d = EXC_W'(DEV_EXC_BASE) + EXC_W'(dev_best.idx);
            default:   exc_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_valid <= 1'b0;
            win_exc   <= '0;
        end else begin
            win_valid <= (src != SRC_NONE);
            win_exc   <= exc_d;
        end
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_nmi_first_R7: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(nmi_req) |-> win_valid && win_exc == EXC_W'(NMI_EXC));

    assert_fault_second_R8: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(hardfault_req && !nmi_req) |-> win_valid && win_exc == EXC_W'(HF_EXC));

    assert_idle_output_R9: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(!nmi_req && !hardfault_req && ((irq_pend & irq_en) == '0))
        |-> !win_valid && win_exc == '0);

    assert_win_eligible_R6: assert property (@(posedge clk) disable iff (rst)
        past_ok && win_valid && win_exc >= EXC_W'(DEV_EXC_BASE)
        |-> |($past(irq_pend & irq_en) & (NUM_IRQ'(1) << (win_exc - EXC_W'(DEV_EXC_BASE)))));

endmodule

// File: tb/irq_prio_arbiter_tb.sv
module irq_prio_arbiter_tb_top;

    localparam int NUM_IRQ   = 8;
    localparam int PRIO_BITS = 3;
    localparam int ADDR_W    = 12;
    localparam int BASE_OFS  = 'h400;
    localparam int EXC_W     = $clog2(16 + NUM_IRQ);

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_wr = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [7:0]         bus_wdata = '0;
    logic [7:0]         bus_rdata;
    logic [NUM_IRQ-1:0] irq_pend = '0;
    logic [NUM_IRQ-1:0] irq_en = '0;
    logic               nmi_req = 1'b0;
    logic               hardfault_req = 1'b0;
    logic               win_valid;
    logic [EXC_W-1:0]   win_exc;

    always #2.5 clk = ~clk;

    irq_prio_arbiter #(
        .NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W), .BASE_OFS(BASE_OFS)
    ) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pend(irq_pend),
        .irq_en(irq_en), .nmi_req(nmi_req), .hardfault_req(hardfault_req),
        .win_valid(win_valid), .win_exc(win_exc)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";
    int    prio_m [NUM_IRQ];
    bit    exp_v  = 1'b0;
    int    exp_e  = 0;
    bit    started = 1'b0;

    function automatic int trunc(input int v);
        return v & ((8'hFF << (8 - PRIO_BITS)) & 8'hFF);
    endfunction

    // Behavioural model: evaluate at the edge, then apply any write.
    always @(posedge clk) begin
        started = 1'b1;
        if (rst) begin
            foreach (prio_m[i]) prio_m[i] = 0;
            exp_v = 1'b0;
            exp_e = 0;
        end else begin
            int best;
            int bp;
            best = -1;
            bp   = 1000;
            for (int k = 0; k < NUM_IRQ; k++) begin
                if (irq_pend[k] && irq_en[k] && prio_m[k] < bp) begin
                    best = k;
                    bp   = prio_m[k];
                end
            end
            if (nmi_req)            begin exp_v = 1; exp_e = 2;         end
            else if (hardfault_req) begin exp_v = 1; exp_e = 3;         end
            else if (best >= 0)     begin exp_v = 1; exp_e = 16 + best; end
            else                    begin exp_v = 0; exp_e = 0;         end
            if (bus_wr && int'(bus_addr) >= BASE_OFS && int'(bus_addr) < BASE_OFS + NUM_IRQ)
                prio_m[int'(bus_addr) - BASE_OFS] = trunc(int'(bus_wdata));
        end
    end

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (win_valid !== exp_v || int'(win_exc) != exp_e) begin
                fails++;
                $display("FAIL %s: valid/exc actual %0d/%0d expected %0d/%0d",
                         tag, win_valid, win_exc, exp_v, exp_e);
            end
        end
    end

    task automatic check_read(input int addr, input int expv, input string t);
        bus_addr = ADDR_W'(addr);
        #0.5;
        checks++;
        if (int'(bus_rdata) != expv) begin
            fails++;
            $display("FAIL %s: read @%0h actual %0h expected %0h", t, addr, bus_rdata, expv);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = 8'(data);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic drive(input logic [NUM_IRQ-1:0] p, input logic [NUM_IRQ-1:0] e,
                         input logic n, input logic h, input string t);
        @(negedge clk);
        tag = t;
        irq_pend = p; irq_en = e; nmi_req = n; hardfault_req = h;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset values
        for (int k = 0; k < NUM_IRQ; k++) check_read(BASE_OFS + k, 0, "R1");

        // R2: low bits dropped
        tag = "R2";
        wr(BASE_OFS + 0, 'hFF);
        check_read(BASE_OFS + 0, 'hE0, "R2");
        wr(BASE_OFS + 1, 'h5F);
        check_read(BASE_OFS + 1, 'h40, "R2");

        // R3: addressing and out-of-range accesses
        tag = "R3";
        wr(BASE_OFS + NUM_IRQ, 'hA0);
        wr(BASE_OFS - 1, 'hA0);
        check_read(BASE_OFS + NUM_IRQ, 0, "R3");
        check_read(BASE_OFS - 1, 0, "R3");
        for (int k = 2; k < NUM_IRQ; k++) check_read(BASE_OFS + k, 0, "R3");
        for (int k = 0; k < NUM_IRQ; k++) wr(BASE_OFS + k, 32 * (NUM_IRQ - 1 - k));
        for (int k = 0; k < NUM_IRQ; k++) check_read(BASE_OFS + k, trunc(32 * (NUM_IRQ - 1 - k)), "R3");

        // R4: smallest priority value wins (highest index has value 0)
        drive(8'hFF, 8'hFF, 0, 0, "R4");
        drive(8'h0F, 8'hFF, 0, 0, "R4");
        drive(8'h05, 8'h05, 0, 0, "R4");

        // R5: ties go to lowest index
        wr(BASE_OFS + 2, 'h40);
        wr(BASE_OFS + 5, 'h40);
        drive(8'h24, 8'hFF, 0, 0, "R5");
        wr(BASE_OFS + 6, 'h40);
        drive(8'h64, 8'hFF, 0, 0, "R5");

        // R6: pending without enable, enable without pending
        drive(8'h80, 8'h7F, 0, 0, "R6");
        drive(8'h01, 8'h80, 0, 0, "R6");

        // R7: non-maskable request wins
        drive(8'h00, 8'h00, 1, 0, "R7");
        drive(8'hFF, 8'hFF, 1, 1, "R7");

        // R8: hard fault second
        drive(8'hFF, 8'hFF, 0, 1, "R8");
        drive(8'h00, 8'h00, 0, 1, "R8");

        // R9: idle
        drive(8'h00, 8'hFF, 0, 0, "R9");

        // R10: output holds until the next edge after an input change
        @(negedge clk);
        tag = "R10";
        irq_pend = 8'h02; irq_en = 8'h02;
        #0.5;
        checks++;
        if (win_valid !== 1'b0) begin
            fails++;
            $display("FAIL R10: valid before edge actual %0d expected 0", win_valid);
        end
        repeat (2) @(negedge clk);
        // R10: priority write reaches arbitration one edge later (model covers timing)
        irq_pend = 8'h03; irq_en = 8'h03;
        wr(BASE_OFS + 1, 'h00);
        wr(BASE_OFS + 0, 'h00);
        repeat (3) @(negedge clk);

        // R1: reset again clears output and registers
        tag = "R1";
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        irq_pend = '0; irq_en = '0;
        check_read(BASE_OFS + 3, 0, "R1");
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule